// File: doc/BRIEF.md
# Comparison and Test-Flag Unit

This unit compares two 16-bit register operands under a 4-bit test-operation code. It keeps the outcome in a single sticky test flag, which later conditional instructions read. A test strobe evaluates the selected comparison. It loads the result into the flag and also into a separate condition register.

Conditional-add and conditional-branch instructions raise a consume strobe when they take effect. The consume strobe clears the flag and leaves the condition register alone. The condition register therefore always shows the outcome of the most recent test, even after a consumer has taken the flag.

Reset is asserted asynchronously through an active-low input. An internal two-stage synchronizer releases it on the clock.

Top module: `testflag_unit`

## Requirements
- R1: While reset is held, and during the two clock edges after reset is released, `flag_o` and `cond_q_o` read 0.
- R2: Code 0 tests A equal to B. Code 1 tests A not equal to B.
- R3: The magnitude tests compare both operands as unsigned numbers: code 2 is A less than B, 3 is A less than or equal to B, 4 is A greater than B and 5 is A greater than or equal to B.
- R4: Code 6 is true only when A and B are both zero.
- R5: Code 7 is true when at least one operand is nonzero. Code 8 is true when both operands are nonzero.
- R6: Codes 9 to 15 evaluate false, so a test with one of them clears the flag.
- R7: A test strobe loads the evaluated condition into `flag_o` and `cond_q_o`, and both are visible after the next rising clock edge.
- R8: A consume strobe without a test clears `flag_o` after the next edge and leaves `cond_q_o` unchanged.
- R9: When a test strobe and a consume strobe arrive in the same cycle, the flag takes the test result.
- R10: With neither strobe asserted, `flag_o` and `cond_q_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First comparison operand (A) |
| op_b | input | 16 | Second comparison operand (B) |
| test_op | input | 4 | Test-operation code |
| test_stb | input | 1 | Evaluate the comparison and load the flag |
| consume_stb | input | 1 | A conditional instruction took the flag; clear it |
| flag_o | output | 1 | Current test flag |
| cond_q_o | output | 1 | Registered result of the most recent test |

## Verification
Both outputs are due exactly one rising edge after the strobe that changes them, and no combinational path reaches either output. The bench drives each stimulus on a falling edge and samples the outputs at the following falling edge. At that point it compares them with a behavioural model that has already been advanced by that stimulus. After reset is released, the bench lets three edges pass before the first strobe, which covers the two-stage release.

// File: rtl/testflag_pkg.sv
package testflag_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    TOP_EQ      = 4'd0,
    TOP_NE      = 4'd1,
    TOP_LT      = 4'd2,
    TOP_LE      = 4'd3,
    TOP_GT      = 4'd4,
    TOP_GE      = 4'd5,
    TOP_BZ      = 4'd6,
    TOP_ANY_NZ  = 4'd7,
    TOP_BOTH_NZ = 4'd8
  } testop_e;
endpackage

// File: rtl/tf_rst_sync.sv
module tf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tf_cmp_eval.sv
module tf_cmp_eval
  import testflag_pkg::*;
#(
  parameter int unsigned W          = DATA_W,
  parameter bit          SIGNED_CMP = 1'b0
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic            cond
);
  logic is_eq, is_lt, a_zero, b_zero;

  assign is_eq  = (a == b);
  assign a_zero = (a == '0);
  assign b_zero = (b == '0);

  generate
    if (SIGNED_CMP) begin : g_signed
      assign is_lt = ($signed(a) < $signed(b));
    end else begin : g_unsigned
      assign is_lt = (a < b);
    end
  endgenerate

  always_comb begin
    case (op)
      TOP_EQ:      cond = is_eq;
      TOP_NE:      cond = !is_eq;
      TOP_LT:      cond = is_lt;
      TOP_LE:      cond = is_lt | is_eq;
      TOP_GT:      cond = !(is_lt | is_eq);
      TOP_GE:      cond = !is_lt;
      TOP_BZ:      cond = is_eq & a_zero;
      TOP_ANY_NZ:  cond = !(a_zero & b_zero);
      TOP_BOTH_NZ: cond = !a_zero & !b_zero;
      default:     cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/tf_flag_reg.sv
module tf_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic test_stb,
  input  logic consume_stb,
  input  logic cond,
  output logic flag_q,
  output logic cond_q
);
  logic flag_d, flag_en;
  logic cond_en;

  always_comb begin
    flag_en = test_stb | consume_stb;
    cond_en = test_stb;
    if (test_stb) flag_d = cond;
    else          flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (cond_en) cond_q <= cond;
    end
  end
endmodule

// File: rtl/testflag_unit.sv
module testflag_unit
  import testflag_pkg::*;
#(
  parameter int unsigned W         = DATA_W,
  parameter int unsigned RST_SYNCS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [OP_W-1:0] test_op,
  input  logic            test_stb,
  input  logic            consume_stb,
  output logic            flag_o,
  output logic            cond_q_o
);
  logic rst_n_int;
  logic cond_now;

  tf_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tf_cmp_eval #(.W(W), .SIGNED_CMP(1'b0)) u_cmp (
    .a    (op_a),
    .b    (op_b),
    .op   (test_op),
    .cond (cond_now)
  );

  tf_flag_reg u_flag (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .test_stb    (test_stb),
    .consume_stb (consume_stb),
    .cond        (cond_now),
    .flag_q      (flag_o),
    .cond_q      (cond_q_o)
  );
endmodule

// File: rtl/testflag_unit_chk.sv
module testflag_unit_chk
  import testflag_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    op_a,
  input logic [W-1:0]    op_b,
  input logic [OP_W-1:0] test_op,
  input logic            test_stb,
  input logic            consume_stb,
  input logic            flag_o,
  input logic            cond_q_o
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> (!flag_o && !cond_q_o));

  a_r9_test_wins: assert property (@(posedge clk) disable iff (!rst_n)
    test_stb |=> (flag_o == cond_q_o));

  a_r8_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_stb && !test_stb) |=> !flag_o);

  a_r8_cond_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !test_stb |=> $stable(cond_q_o));

  a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_stb && !consume_stb) |=> $stable(flag_o));

  a_r6_reserved_false: assert property (@(posedge clk) disable iff (!rst_n)
    (test_stb && (test_op > 4'd8)) |=> !flag_o);

  a_r4_bothzero_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (test_stb && test_op == 4'd6 && (op_a != '0 || op_b != '0)) |=> !flag_o);

  a_r2_eq_false: assert property (@(posedge clk) disable iff (!rst_n)
    (test_stb && test_op == 4'd0 && op_a != op_b) |=> !flag_o);
endmodule

bind testflag_unit testflag_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_a        (op_a),
  .op_b        (op_b),
  .test_op     (test_op),
  .test_stb    (test_stb),
  .consume_stb (consume_stb),
  .flag_o      (flag_o),
  .cond_q_o    (cond_q_o)
);

// File: tb/testflag_unit_tb.sv
module testflag_unit_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [3:0]  test_op;
  logic        test_stb, consume_stb;
  logic        flag_o, cond_q_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit m_flag = 0;
  bit m_cond = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  testflag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .test_op(test_op),
    .test_stb(test_stb), .consume_stb(consume_stb),
    .flag_o(flag_o), .cond_q_o(cond_q_o)
  );

  function automatic bit ref_eval(int unsigned a, int unsigned b, int unsigned op);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return a < b;
      3: return a <= b;
      4: return a > b;
      5: return a >= b;
      6: return (a == 0) && (b == 0);
      7: return (a != 0) || (b != 0);
      8: return (a != 0) && (b != 0);
      default: return 0;
    endcase
  endfunction

  function automatic string op_req(int unsigned op);
    if (op <= 1) return "R2";
    if (op <= 5) return "R3";
    if (op == 6) return "R4";
    if (op <= 8) return "R5";
    return "R6";
  endfunction

  task automatic check(input logic got, input bit exp, input string req, input string what);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                      input bit t, input bit c, input string req);
    bit r;
    op_a = a; op_b = b; test_op = op; test_stb = t; consume_stb = c;
    if (t) begin
      r = ref_eval(a, b, op);
      m_flag = r;
      m_cond = r;
    end else if (c) begin
      m_flag = 0;
    end
    @(negedge clk);
    check(flag_o, m_flag, req, "flag");
    check(cond_q_o, m_cond, req, "cond");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] pa [6] = '{16'h0000, 16'h0000, 16'h0001, 16'h0007, 16'h8000, 16'hFFFF};
    logic [15:0] pb [6] = '{16'h0000, 16'h0001, 16'h0000, 16'h0007, 16'h7FFF, 16'hFFFF};
    rst_n = 0; op_a = 0; op_b = 0; test_op = 0; test_stb = 0; consume_stb = 0;
    repeat (3) @(negedge clk);
    check(flag_o, 0, "R1", "flag in reset");
    check(cond_q_o, 0, "R1", "cond in reset");
    // Strobe during reset must not take effect (R1)
    test_stb = 1;
    @(negedge clk);
    check(flag_o, 0, "R1", "flag strobed in reset");
    test_stb = 0;
    rst_n = 1;
    repeat (3) step(16'h0, 16'h0, 4'd0, 0, 0, "R1");

    // R7: set, then clear through a failing test
    step(16'h1234, 16'h1234, 4'd0, 1, 0, "R7");
    step(16'h1234, 16'h1235, 4'd0, 1, 0, "R7");
    // R10: hold with no strobes
    step(16'h0001, 16'h0002, 4'd2, 1, 0, "R3");
    repeat (4) step(16'hAAAA, 16'h5555, 4'd0, 0, 0, "R10");
    // R8: consume clears flag, cond kept
    step(16'h0, 16'h0, 4'd0, 0, 1, "R8");
    step(16'h0, 16'h0, 4'd0, 0, 1, "R8");
    step(16'h0, 16'h0, 4'd0, 0, 0, "R10");
    // R9: test wins over consume, both outcomes
    step(16'h0005, 16'h0003, 4'd4, 1, 1, "R9");
    step(16'h0005, 16'h0003, 4'd2, 1, 1, "R9");
    step(16'h0000, 16'h0000, 4'd6, 1, 1, "R9");
    // R3 unsigned boundary
    step(16'h0000, 16'hFFFF, 4'd2, 1, 0, "R3");
    step(16'hFFFF, 16'h0000, 4'd4, 1, 0, "R3");
    step(16'h7FFF, 16'h8000, 4'd5, 1, 0, "R3");
    // R6: reserved clears a set flag
    step(16'h1, 16'h1, 4'd0, 1, 0, "R2");
    step(16'h1, 16'h1, 4'd9, 1, 0, "R6");
    step(16'h1, 16'h1, 4'd0, 1, 0, "R2");
    step(16'h0, 16'h0, 4'd15, 1, 0, "R6");

    // Sweep every code over a set of operand pairs, with consumes interleaved
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 6; k++) begin
        step(pa[k], pb[k], op[3:0], 1, 0, op_req(op));
        if (k == 3) step(16'h0, 16'h0, 4'd0, 0, 1, "R8");
      end
    end
    step(16'h0, 16'h0, 4'd0, 0, 0, "R10");
    finish_run();
  end
endmodule